// File: doc/BRIEF.md
# PWM Fault Shutdown Guard

This block sits between a PWM generator and the inverter gate drivers. It passes the six gate signals through unchanged in normal operation. It forces every one of them to its OFF level when a fault is present. A fault comes from one of two sources. The first is an active-low trip pin: the pin is pulled down on the board, so an open pin reads as a fault. The second is a software write to a one-bit shutdown register. The path from the trip pin to the outputs has no clock in it. A low pin blocks the gates within the same cycle, with no wait for an edge.

While the block is shut down it also blocks the generator's sync pulse and sync interrupt, and it issues one trip interrupt for each shutdown event. The shutdown state is latched. It stays set after the pin returns high, and it clears only on an explicit restart write, which is taken only while the synchronized pin reads high. Software reads the pin level and the latched state through a status register. Software reads the source of the shutdown through the software-trip register, and that read also clears the source flag.

Top module: `pwm_fault_guard`

## Requirements
- R1: While `trip_n` is 0, `pwm_out` equals the OFF pattern (parameter `OFF_LEVEL`, default all zeros) in the same cycle, with no clock edge needed.
- R2: A shutdown is latched. After `trip_n` returns to 1, `pwm_out` stays at the OFF pattern until a restart is accepted.
- R3: While `trip_n` is 0 or the shutdown is latched, `sync_out` and `sync_irq_out` are 0.
- R4: `trip_irq` is high for exactly one cycle per shutdown event. For a pin trip it rises at the third rising edge after `trip_n` falls. For a software trip it rises at the edge that accepts the write.
- R5: A read of address 0 returns bit 0 = the level of `trip_n` after two synchronizing flops, and bit 1 = the latched shutdown state. All other bits read 0.
- R6: A write to address 1 with data bit 0 = 1 latches a shutdown identical to a pin trip. A write with data bit 0 = 0 has no effect.
- R7: A read of address 1 returns bit 0 = 1 when the last shutdown came from software, and that read clears the bit. A shutdown started by the pin leaves the bit 0.
- R8: A write to address 2 with data bit 0 = 1 clears the latched shutdown only while the synchronized pin is 1. Otherwise the write is ignored.
- R9: After reset, the shutdown is not latched, the source flag is 0, `trip_irq` is 0 and `reg_rdata` is 0.
- R10: Outside shutdown, `pwm_out`, `sync_out` and `sync_irq_out` follow their inputs combinationally.
- R11: `reg_rdata` is loaded at the rising edge on which `reg_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_n | input | 1 | Fault pin, low = fault |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pwm_in | input | 6 | Gate signals from the PWM generator |
| pwm_out | output | 6 | Gate signals to the drivers |
| sync_in | input | 1 | Sync pulse from the generator |
| sync_out | output | 1 | Gated sync pulse |
| sync_irq_in | input | 1 | Sync interrupt from the generator |
| sync_irq_out | output | 1 | Gated sync interrupt |
| trip_irq | output | 1 | One-cycle trip interrupt |

## Verification
Several properties are checked on every clock cycle:
- a low pin always shows the OFF pattern;
- a latched shutdown keeps sync and sync interrupt silent;
- the trip interrupt never lasts two cycles;
- an accepted software trip always latches;
- the latch falls only after a restart write that arrived with the synchronized pin high.

The directed scenarios cover the rest. They show the exact edge on which the interrupt arrives, and the once-per-event count across several events. They also show a restart ignored while the pin is low, the read-to-clear of the source flag, and a disabling write with bit 0 clear that leaves everything untouched.

// File: rtl/pfg_pkg.sv
// Package: shared constants for the PWM fault shutdown guard.
// Assumes a small register space of four word addresses.
package pfg_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_SWTRIP  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_RESTART = 2'd2;

    // Status bit positions
    localparam int ST_PIN_BIT   = 0;
    localparam int ST_LATCH_BIT = 1;
endpackage

// File: rtl/pfg_sync.sv
// Module: multi-flop synchronizer for a single asynchronous level.
// Assumes the input may change at any time. The output is delayed by
// STAGES rising edges. RST_VAL is the value held during reset.
module pfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pfg_reg_port.sv
// Module: register decode and registered read mux.
// Produces single-cycle strobes from the write and read port.
// Assumes at most one of reg_wr and reg_rd is used per cycle by software;
// both are handled independently anyway.
module pfg_reg_port
    import pfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              pin_ok,
    input  logic              latched,
    input  logic              soft_flag,
    output logic              soft_set,
    output logic              restart_req,
    output logic              soft_rd,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [DATA_W-1:0] rd_mux;

    // Decode write and read strobes
    always_comb begin
        soft_set    = reg_wr && (reg_addr == ADR_SWTRIP)  && reg_wdata[0];
        restart_req = reg_wr && (reg_addr == ADR_RESTART) && reg_wdata[0];
        soft_rd     = reg_rd && (reg_addr == ADR_SWTRIP);
    end

    // Select the word presented for the addressed register
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ADR_STATUS: begin
                rd_mux[ST_PIN_BIT]   = pin_ok;
                rd_mux[ST_LATCH_BIT] = latched;
            end
            ADR_SWTRIP: rd_mux[0] = soft_flag;
            default:    rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R11: read data changes only on a read
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) && $past(rst_n) |-> $stable(reg_rdata));
endmodule

// File: rtl/pfg_fault_latch.sv
// Module: shutdown latch, trip interrupt and software source flag.
// Assumes pin_ok is already synchronized. A set request (pin low or
// software write) wins over a restart in the same cycle.
module pfg_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_ok,
    input  logic soft_set,
    input  logic restart_req,
    input  logic soft_rd,
    output logic latched,
    output logic trip_irq,
    output logic soft_flag
);
    logic set_ev;
    logic new_event;

    // A shutdown request is present this cycle
    always_comb begin
        set_ev    = soft_set || !pin_ok;
        new_event = set_ev && !latched;
    end

    // Hold shutdown until an accepted restart
    always_ff @(posedge clk) begin
        if (!rst_n)                     latched <= 1'b0;
        else if (set_ev)                latched <= 1'b1;
        else if (restart_req && pin_ok) latched <= 1'b0;
    end

    // One-cycle interrupt at the start of each event
    always_ff @(posedge clk) begin
        if (!rst_n) trip_irq <= 1'b0;
        else        trip_irq <= new_event;
    end

    // Remember whether the latest shutdown came from software
    always_ff @(posedge clk) begin
        if (!rst_n)         soft_flag <= 1'b0;
        else if (soft_set)  soft_flag <= 1'b1;
        else if (new_event) soft_flag <= 1'b0;
        else if (soft_rd)   soft_flag <= 1'b0;
    end

    // R4: the interrupt never lasts longer than one cycle
    a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trip_irq |=> !trip_irq);

    // R6: an accepted software trip always latches
    a_r6_soft_latches: assert property (@(posedge clk) disable iff (!rst_n)
        soft_set |=> latched);

    // R8: the latch falls only on a restart with the pin high
    a_r8_restart_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(latched) |-> $past(restart_req) && $past(pin_ok));

    // R7: a read without a new set clears the source flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rd && !soft_set |=> !soft_flag);
endmodule

// File: rtl/pfg_gate.sv
// Module: combinational output gating. No clock anywhere on this path.
// Assumes fault_now already combines the raw pin and the latched state.
module pfg_gate #(
    parameter int              N_CH      = 6,
    parameter logic [N_CH-1:0] OFF_LEVEL = '0
) (
    input  logic            fault_now,
    input  logic [N_CH-1:0] pwm_in,
    input  logic            sync_in,
    input  logic            sync_irq_in,
    output logic [N_CH-1:0] pwm_out,
    output logic            sync_out,
    output logic            sync_irq_out
);
    // Per-channel force to the OFF level
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign pwm_out[g] = fault_now ? OFF_LEVEL[g] : pwm_in[g];
    end

    // Block sync pulse and sync interrupt
    assign sync_out     = sync_in     && !fault_now;
    assign sync_irq_out = sync_irq_in && !fault_now;
endmodule

// File: rtl/pwm_fault_guard.sv
// Module: top of the PWM fault shutdown guard.
// Raw trip_n forces the outputs asynchronously. A synchronized copy
// drives the latch, the interrupt and the status register.
// Assumes active-low trip_n is pulled down on the board.
module pwm_fault_guard
    import pfg_pkg::*;
#(
    parameter int              N_CH        = 6,
    parameter int              SYNC_STAGES = 2,
    parameter logic [N_CH-1:0] OFF_LEVEL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_CH-1:0]   pwm_in,
    output logic [N_CH-1:0]   pwm_out,
    input  logic              sync_in,
    output logic              sync_out,
    input  logic              sync_irq_in,
    output logic              sync_irq_out,
    output logic              trip_irq
);
    logic pin_ok;
    logic latched;
    logic soft_flag;
    logic soft_set;
    logic restart_req;
    logic soft_rd;
    logic fault_now;

    pfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trip_n), .sync_out(pin_ok));

    pfg_reg_port i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pin_ok(pin_ok),
        .latched(latched), .soft_flag(soft_flag), .soft_set(soft_set),
        .restart_req(restart_req), .soft_rd(soft_rd), .reg_rdata(reg_rdata));

    pfg_fault_latch i_latch (
        .clk(clk), .rst_n(rst_n), .pin_ok(pin_ok), .soft_set(soft_set),
        .restart_req(restart_req), .soft_rd(soft_rd), .latched(latched),
        .trip_irq(trip_irq), .soft_flag(soft_flag));

    // Fault is the raw pin OR the latched state
    assign fault_now = !trip_n || latched;

    pfg_gate #(.N_CH(N_CH), .OFF_LEVEL(OFF_LEVEL)) i_gate (
        .fault_now(fault_now), .pwm_in(pwm_in), .sync_in(sync_in),
        .sync_irq_in(sync_irq_in), .pwm_out(pwm_out), .sync_out(sync_out),
        .sync_irq_out(sync_irq_out));

    // R1: a low pin always shows the OFF pattern
    a_r1_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_n |-> pwm_out == OFF_LEVEL);

    // R3: latched shutdown keeps sync silent
    a_r3_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> !sync_out && !sync_irq_out);

    // R2: latched shutdown keeps gates off
    a_r2_latched_off: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> pwm_out == OFF_LEVEL);
endmodule

// File: tb/test_pwm_fault_guard.sv
module test_pwm_fault_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trip_n = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] pwm_in = 6'b101101;
    logic [5:0] pwm_out;
    logic       sync_in = 1'b1;
    logic       sync_out;
    logic       sync_irq_in = 1'b1;
    logic       sync_irq_out;
    logic       trip_irq;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;

    always #2 clk = ~clk;

    pwm_fault_guard i_pwm_fault_guard (
        .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pwm_in(pwm_in), .pwm_out(pwm_out),
        .sync_in(sync_in), .sync_out(sync_out), .sync_irq_in(sync_irq_in),
        .sync_irq_out(sync_irq_out), .trip_irq(trip_irq));

    always @(negedge clk) if (rst_n && trip_irq) irq_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rdata", reg_rdata, 0);
        check("R9 irq", trip_irq, 0);
        check("R9 passthrough", pwm_out, pwm_in);
        rd(2'd0, d);
        check("R9 status not latched", d, 8'h01);
        rd(2'd1, d);
        check("R9 flag clear", d, 0);
    endtask

    task automatic t_pass;
        for (int k = 0; k < 4; k++) begin
            pwm_in = 6'(k * 21 + 5);
            sync_in = k[0]; sync_irq_in = k[1];
            #1;
            check("R10 pwm follows", pwm_out, pwm_in);
            check("R10 sync follows", sync_out, sync_in);
            check("R10 syncirq follows", sync_irq_out, sync_irq_in);
        end
        sync_in = 1'b1; sync_irq_in = 1'b1; pwm_in = 6'b111111;
    endtask

    task automatic t_hw_trip;
        logic [7:0] d;
        int c0 = irq_cnt;
        @(negedge clk);
        trip_n = 1'b0;
        #0.5;
        check("R1 async off", pwm_out, 6'b0);
        check("R3 sync off", sync_out, 0);
        check("R3 syncirq off", sync_irq_out, 0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R4 irq edge", trip_irq, (k == 3));
        end
        trip_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 stays off", pwm_out, 6'b0);
        check("R3 sync still off", sync_out, 0);
        rd(2'd0, d);
        check("R5 status", d, 8'h03);
        rd(2'd1, d);
        check("R7 hw source", d, 0);
        check("R4 once per event", irq_cnt - c0, 1);
        wr(2'd2, 8'h01);
        check("R8 restart accepted", pwm_out, pwm_in);
        rd(2'd0, d);
        check("R5 status after restart", d, 8'h01);
    endtask

    task automatic t_blocked_restart;
        logic [7:0] d;
        int c0 = irq_cnt;
        @(negedge clk);
        trip_n = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, d);
        check("R5 pin low read", d, 8'h02);
        wr(2'd2, 8'h01);
        trip_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(2'd0, d);
        check("R8 restart ignored", d, 8'h03);
        check("R8 still off", pwm_out, 6'b0);
        wr(2'd2, 8'h01);
        check("R8 restart ok", pwm_out, pwm_in);
        check("R4 one irq", irq_cnt - c0, 1);
    endtask

    task automatic t_soft;
        logic [7:0] d;
        int c0 = irq_cnt;
        wr(2'd1, 8'h00);
        check("R6 zero write ignored", pwm_out, pwm_in);
        rd(2'd0, d);
        check("R6 zero write no latch", d, 8'h01);
        check("R6 zero write no irq", irq_cnt - c0, 0);
        wr(2'd1, 8'h01);
        check("R4 soft irq", trip_irq, 1);
        check("R6 soft off", pwm_out, 6'b0);
        check("R3 soft sync off", sync_irq_out, 0);
        rd(2'd1, d);
        check("R7 soft source", d, 8'h01);
        rd(2'd1, d);
        check("R7 read cleared", d, 0);
        check("R4 soft once", irq_cnt - c0, 1);
        wr(2'd2, 8'h01);
        check("R8 soft restart", pwm_out, pwm_in);
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_pass();
        t_hw_trip();
        t_blocked_restart();
        t_soft();
        t_hw_trip();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule